// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control sequencer for a multicycle 32-bit load/store processor built around one shared memory and one ALU. It steps every instruction through a shared fetch cycle and a shared decode cycle. It then runs a short class-specific tail, so the whole instruction takes three to five clock cycles. In every cycle it drives the datapath select and enable lines from its present state alone. The only exception is the effective PC enable, which also folds in the ALU zero flag.

Two exception paths are built in. The first is taken when an opcode is not recognised at decode. The second is taken when an R-type operation overflows. Both spend one cycle in which they:
- save PC minus 4 into the exception PC register;
- write a cause code;
- load the PC with the fixed handler address.

After that cycle the controller returns to fetch. An overflowing R-type never reaches its register write-back cycle.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_ni` is low (asynchronous), and in the first cycle after release, the fetch controls are driven: mem_rd=1, addr_sel=0, ir_wr=1, opa_sel=0, opb_sel=01, alu_cls=00, pc_wr=1, pc_src=00, and every other control is 0.
- R2: The cycle after fetch is decode. It drives opa_sel=0, opb_sel=11 and alu_cls=00, and asserts no memory, register, PC, EPC or cause write.
- R3: Instruction lengths from fetch back to fetch are as follows: load (opcode 100011) takes 5 cycles; store (101011) takes 4; R-type (000000) takes 4; branch-equal (000100) takes 3; jump (000010) takes 3.
- R4: A load runs in three steps. The address cycle drives opa_sel=1, opb_sel=10 and alu_cls=00. The read cycle drives mem_rd=1 and addr_sel=1. The write-back cycle drives rf_wr=1, wb_sel=1 and dst_sel=0.
- R5: A store uses the same address cycle as a load and then drives mem_wr=1 and addr_sel=1, with rf_wr=0.
- R6: An R-type first runs an execute cycle with opa_sel=1, opb_sel=00 and alu_cls=10. It then runs a write-back cycle with rf_wr=1, dst_sel=1 and wb_sel=0.
- R7: The branch cycle drives opa_sel=1, opb_sel=00, alu_cls=01, pc_wr_cond=1 and pc_src=01. In that cycle pc_en_o equals zero_i.
- R8: The jump cycle drives pc_wr=1 and pc_src=10.
- R9: An unrecognised opcode at decode is followed by one exception cycle. That cycle drives epc_wr=1, cause_wr=1, cause code 0, opa_sel=0, opb_sel=01, alu_cls=01 (PC minus 4), pc_wr=1 and pc_src=11 (handler vector). Fetch follows it.
- R10: If ovf_i is high during the R-type execute cycle, the next cycle is the exception cycle with cause code 1 in place of the write-back cycle. No rf_wr is asserted for that instruction.
- R11: pc_en_o = pc_wr OR (pc_wr_cond AND zero_i). mem_rd and mem_wr are never high together.
- R12: ovf_i is ignored outside the R-type execute cycle. A load or a branch with ovf_i high completes its normal sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| zero_i | input | 1 | ALU result is zero |
| ovf_i | input | 1 | ALU signed overflow |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_wr_o | output | 1 | Instruction register write |
| rf_wr_o | output | 1 | Register file write |
| dst_sel_o | output | 1 | Destination: 0 rt field, 1 rd field |
| wb_sel_o | output | 1 | Write-back: 0 ALU output register, 1 memory data register |
| opa_sel_o | output | 1 | ALU operand A: 0 PC, 1 A register |
| opb_sel_o | output | 2 | ALU operand B: 00 B reg, 01 constant 4, 10 sign-extended immediate, 11 immediate shifted by 2 |
| alu_cls_o | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write when zero |
| pc_src_o | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 jump target, 11 handler vector |
| pc_en_o | output | 1 | Effective PC enable |
| epc_wr_o | output | 1 | Exception PC write |
| cause_wr_o | output | 1 | Cause register write |
| cause_code_o | output | 32 | Cause value: 0 undefined opcode, 1 overflow, 0 when not writing |

## Verification
The ALU overflow flag can be raised in the same cycle as other uses of the ALU. The branch compare is one example, since it is a subtraction, and load address generation is another. Only the R-type execute cycle may act on that flag. The stimulus table drives ovf_i high across entire branch, load and R-type instructions, and zero_i high across jumps. Each cycle's control word is then checked: the branch and load sequences must stay intact, while the R-type one must divert to the overflow exception with cause 1 and no register write.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

  typedef enum logic [3:0] {
    S_FETCH = 4'd0, S_DEC   = 4'd1, S_MADDR = 4'd2, S_LDRD = 4'd3,
    S_LDWB  = 4'd4, S_STWR  = 4'd5, S_REXE  = 4'd6, S_RWB  = 4'd7,
    S_BEQ   = 4'd8, S_JMP   = 4'd9, S_XUND  = 4'd10, S_XOVF = 4'd11
  } state_t;

  localparam logic [1:0] OPB_REG    = 2'b00;
  localparam logic [1:0] OPB_FOUR   = 2'b01;
  localparam logic [1:0] OPB_IMM    = 2'b10;
  localparam logic [1:0] OPB_IMM_SH = 2'b11;

  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_SUB   = 2'b01;
  localparam logic [1:0] ALU_FUNCT = 2'b10;

  localparam logic [1:0] PCS_ALU = 2'b00;
  localparam logic [1:0] PCS_OUT = 2'b01;
  localparam logic [1:0] PCS_JMP = 2'b10;
  localparam logic [1:0] PCS_VEC = 2'b11;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_wr;
    logic       rf_wr;
    logic       dst_sel;
    logic       wb_sel;
    logic       opa_sel;
    logic [1:0] opb_sel;
    logic [1:0] alu_cls;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic [1:0] pc_src;
    logic       epc_wr;
    logic       cause_wr;
    logic       exc_ovf;
  } ctrl_t;
endpackage

// File: rtl/mc_state_reg.sv
module mc_state_reg
  import mc_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  state_t nxt_i,
  output state_t state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= S_FETCH;
    else         state_o <= nxt_i;
  end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_t          state_i,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            ovf_i,
  output state_t          nxt_o
);
  state_t dispatch;

  always_comb begin
    case (opcode_i)
      OPC_RTYPE:          dispatch = S_REXE;
      OPC_LOAD, OPC_STORE: dispatch = S_MADDR;
      OPC_BEQ:            dispatch = S_BEQ;
      OPC_JUMP:           dispatch = S_JMP;
      default:            dispatch = S_XUND;
    endcase
  end

  always_comb begin
    case (state_i)
      S_FETCH: nxt_o = S_DEC;
      S_DEC:   nxt_o = dispatch;
      S_MADDR: nxt_o = (opcode_i == OPC_LOAD) ? S_LDRD : S_STWR;
      S_LDRD:  nxt_o = S_LDWB;
      // overflow seen during execute pre-empts the write-back
      S_REXE:  nxt_o = ovf_i ? S_XOVF : S_RWB;
      default: nxt_o = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  state_t state_i,
  output ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    case (state_i)
      S_FETCH: begin
        ctrl_o.mem_rd  = 1'b1;
        ctrl_o.ir_wr   = 1'b1;
        ctrl_o.opb_sel = OPB_FOUR;
        ctrl_o.alu_cls = ALU_ADD;
        ctrl_o.pc_wr   = 1'b1;
        ctrl_o.pc_src  = PCS_ALU;
      end
      S_DEC: ctrl_o.opb_sel = OPB_IMM_SH;
      S_MADDR: begin
        ctrl_o.opa_sel = 1'b1;
        ctrl_o.opb_sel = OPB_IMM;
      end
      S_LDRD: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      S_LDWB: begin
        ctrl_o.rf_wr  = 1'b1;
        ctrl_o.wb_sel = 1'b1;
      end
      S_STWR: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      S_REXE: begin
        ctrl_o.opa_sel = 1'b1;
        ctrl_o.opb_sel = OPB_REG;
        ctrl_o.alu_cls = ALU_FUNCT;
      end
      S_RWB: begin
        ctrl_o.rf_wr   = 1'b1;
        ctrl_o.dst_sel = 1'b1;
      end
      S_BEQ: begin
        ctrl_o.opa_sel    = 1'b1;
        ctrl_o.alu_cls    = ALU_SUB;
        ctrl_o.pc_wr_cond = 1'b1;
        ctrl_o.pc_src     = PCS_OUT;
      end
      S_JMP: begin
        ctrl_o.pc_wr  = 1'b1;
        ctrl_o.pc_src = PCS_JMP;
      end
      S_XUND, S_XOVF: begin
        ctrl_o.opb_sel  = OPB_FOUR;
        ctrl_o.alu_cls  = ALU_SUB;
        ctrl_o.pc_wr    = 1'b1;
        ctrl_o.pc_src   = PCS_VEC;
        ctrl_o.epc_wr   = 1'b1;
        ctrl_o.cause_wr = 1'b1;
        ctrl_o.exc_ovf  = (state_i == S_XOVF);
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int CAUSE_W     = 32,
  parameter int CAUSE_UNDEF = 0,
  parameter int CAUSE_OVF   = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [OP_W-1:0]    opcode_i,
  input  logic               zero_i,
  input  logic               ovf_i,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               addr_sel_o,
  output logic               ir_wr_o,
  output logic               rf_wr_o,
  output logic               dst_sel_o,
  output logic               wb_sel_o,
  output logic               opa_sel_o,
  output logic [1:0]         opb_sel_o,
  output logic [1:0]         alu_cls_o,
  output logic               pc_wr_o,
  output logic               pc_wr_cond_o,
  output logic [1:0]         pc_src_o,
  output logic               pc_en_o,
  output logic               epc_wr_o,
  output logic               cause_wr_o,
  output logic [CAUSE_W-1:0] cause_code_o
);
  state_t state, nxt;
  ctrl_t  ctrl;

  mc_state_reg u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt),
    .state_o(state)
  );

  mc_next_state u_next (
    .state_i (state),
    .opcode_i(opcode_i),
    .ovf_i   (ovf_i),
    .nxt_o   (nxt)
  );

  mc_ctrl_decode u_dec (
    .state_i(state),
    .ctrl_o (ctrl)
  );

  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign addr_sel_o   = ctrl.addr_sel;
  assign ir_wr_o      = ctrl.ir_wr;
  assign rf_wr_o      = ctrl.rf_wr;
  assign dst_sel_o    = ctrl.dst_sel;
  assign wb_sel_o     = ctrl.wb_sel;
  assign opa_sel_o    = ctrl.opa_sel;
  assign opb_sel_o    = ctrl.opb_sel;
  assign alu_cls_o    = ctrl.alu_cls;
  assign pc_wr_o      = ctrl.pc_wr;
  assign pc_wr_cond_o = ctrl.pc_wr_cond;
  assign pc_src_o     = ctrl.pc_src;
  assign epc_wr_o     = ctrl.epc_wr;
  assign cause_wr_o   = ctrl.cause_wr;

  assign pc_en_o = ctrl.pc_wr | (ctrl.pc_wr_cond & zero_i);

  always_comb begin
    if (!ctrl.cause_wr)    cause_code_o = '0;
    else if (ctrl.exc_ovf) cause_code_o = CAUSE_W'(CAUSE_OVF);
    else                   cause_code_o = CAUSE_W'(CAUSE_UNDEF);
  end

  AST_MEM_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R11

  AST_PC_EN_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_en_o |-> (pc_wr_o || zero_i)); // R11

  AST_OVF_DIVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_REXE && ovf_i) |=> (cause_wr_o && !rf_wr_o)); // R10

  AST_BEQ_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_cond_o |=> ir_wr_o); // R7

  AST_JUMP_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_DEC && opcode_i == OPC_JUMP) |=> (pc_src_o == PCS_JMP)); // R8

  AST_EXC_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_wr_o |=> (state == S_FETCH)); // R9

  AST_DEC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |=> !(rf_wr_o || mem_wr_o || pc_wr_o || epc_wr_o)); // R2
endmodule

// File: tb/mc_ctrl_fsm_test.sv
module mc_ctrl_fsm_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic        zero_i = 1'b0;
  logic        ovf_i = 1'b0;
  logic        mem_rd_o, mem_wr_o, addr_sel_o, ir_wr_o, rf_wr_o, dst_sel_o;
  logic        wb_sel_o, opa_sel_o, pc_wr_o, pc_wr_cond_o, pc_en_o;
  logic        epc_wr_o, cause_wr_o;
  logic [1:0]  opb_sel_o, alu_cls_o, pc_src_o;
  logic [31:0] cause_code_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  mc_ctrl_fsm uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i), .zero_i(zero_i),
    .ovf_i(ovf_i), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .addr_sel_o(addr_sel_o), .ir_wr_o(ir_wr_o), .rf_wr_o(rf_wr_o),
    .dst_sel_o(dst_sel_o), .wb_sel_o(wb_sel_o), .opa_sel_o(opa_sel_o),
    .opb_sel_o(opb_sel_o), .alu_cls_o(alu_cls_o), .pc_wr_o(pc_wr_o),
    .pc_wr_cond_o(pc_wr_cond_o), .pc_src_o(pc_src_o), .pc_en_o(pc_en_o),
    .epc_wr_o(epc_wr_o), .cause_wr_o(cause_wr_o), .cause_code_o(cause_code_o)
  );

  // phase codes
  localparam logic [3:0] P_F = 0, P_D = 1, P_MA = 2, P_LR = 3, P_LW = 4,
    P_SW = 5, P_RX = 6, P_RW = 7, P_BR = 8, P_J = 9, P_XU = 10, P_XO = 11;

  // {mem_rd,mem_wr,addr_sel,ir_wr,rf_wr,dst_sel,wb_sel,opa,opb[2],alu[2],pc_wr,pc_cond,pc_src[2],epc,cause}
  function automatic logic [17:0] exp_ctrl(input logic [3:0] p);
    case (p)
      P_F:  return 18'b1_0_0_1_0_0_0_0_01_00_1_0_00_0_0;
      P_D:  return 18'b0_0_0_0_0_0_0_0_11_00_0_0_00_0_0;
      P_MA: return 18'b0_0_0_0_0_0_0_1_10_00_0_0_00_0_0;
      P_LR: return 18'b1_0_1_0_0_0_0_0_00_00_0_0_00_0_0;
      P_LW: return 18'b0_0_0_0_1_0_1_0_00_00_0_0_00_0_0;
      P_SW: return 18'b0_1_1_0_0_0_0_0_00_00_0_0_00_0_0;
      P_RX: return 18'b0_0_0_0_0_0_0_1_00_10_0_0_00_0_0;
      P_RW: return 18'b0_0_0_0_1_1_0_0_00_00_0_0_00_0_0;
      P_BR: return 18'b0_0_0_0_0_0_0_1_00_01_0_1_01_0_0;
      P_J:  return 18'b0_0_0_0_0_0_0_0_00_00_1_0_10_0_0;
      default: return 18'b0_0_0_0_0_0_0_0_01_01_1_0_11_1_1;
    endcase
  endfunction

  function automatic string phase_tag(input logic [3:0] p);
    case (p)
      P_F: return "R1/R3";
      P_D: return "R2";
      P_MA, P_LR, P_LW: return "R4";
      P_SW: return "R5";
      P_RX, P_RW: return "R6";
      P_BR: return "R7";
      P_J: return "R8";
      P_XU: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [17:0] act_ctrl();
    return {mem_rd_o, mem_wr_o, addr_sel_o, ir_wr_o, rf_wr_o, dst_sel_o,
            wb_sel_o, opa_sel_o, opb_sel_o, alu_cls_o, pc_wr_o, pc_wr_cond_o,
            pc_src_o, epc_wr_o, cause_wr_o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_phase(input logic [3:0] p, input string tag);
    logic [17:0] e;
    logic        e_en;
    logic [31:0] e_cause;
    e = exp_ctrl(p);
    e_en = e[5] | (e[4] & zero_i); // R11: pc_wr | (pc_cond & zero)
    e_cause = (p == P_XO) ? 32'd1 : 32'd0;
    chk(act_ctrl() == e, tag, 32'(act_ctrl()), 32'(e));
    chk(pc_en_o == e_en, "R11", 32'(pc_en_o), 32'(e_en));
    chk(!(mem_rd_o && mem_wr_o), "R11", 32'(mem_wr_o), 32'd0);
    chk(cause_code_o == e_cause, tag, cause_code_o, e_cause);
  endtask

  // {opcode[6], zero, ovf, nphase[3], phases 5x4 (first in low nibble)}
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {6'b100011, 1'b0, 1'b0, 3'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, // R3 load
    {6'b101011, 1'b0, 1'b0, 3'd4, 4'd0, 4'd5, 4'd2, 4'd1, 4'd0}, // R3 store
    {6'b000000, 1'b0, 1'b0, 3'd4, 4'd0, 4'd7, 4'd6, 4'd1, 4'd0}, // R3 R-type
    {6'b000000, 1'b1, 1'b1, 3'd4, 4'd0, 4'd11, 4'd6, 4'd1, 4'd0}, // R10
    {6'b000100, 1'b1, 1'b0, 3'd3, 4'd0, 4'd0, 4'd8, 4'd1, 4'd0}, // R7 taken
    {6'b000100, 1'b0, 1'b0, 3'd3, 4'd0, 4'd0, 4'd8, 4'd1, 4'd0}, // R7 not taken
    {6'b000100, 1'b1, 1'b1, 3'd3, 4'd0, 4'd0, 4'd8, 4'd1, 4'd0}, // R12
    {6'b000010, 1'b0, 1'b0, 3'd3, 4'd0, 4'd0, 4'd9, 4'd1, 4'd0}, // R8
    {6'b001000, 1'b0, 1'b0, 3'd3, 4'd0, 4'd0, 4'd10, 4'd1, 4'd0}, // R9
    {6'b111111, 1'b0, 1'b1, 3'd3, 4'd0, 4'd0, 4'd10, 4'd1, 4'd0}, // R9
    {6'b100011, 1'b0, 1'b1, 3'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, // R12
    {6'b000010, 1'b1, 1'b0, 3'd3, 4'd0, 4'd0, 4'd9, 4'd1, 4'd0}  // R8
  };

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: held in reset
    repeat (2) @(negedge clk_i);
    #2 chk_phase(P_F, "R1");
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < int'(VEC[v][22:20]); i++) begin
        logic [3:0] p;
        string      tag;
        opcode_i = VEC[v][30:25];
        zero_i   = VEC[v][24];
        ovf_i    = VEC[v][23];
        p = VEC[v][4*i +: 4];
        tag = (ovf_i && opcode_i != 6'b000000) ? "R12" : phase_tag(p);
        #2 chk_phase(p, tag);
        @(negedge clk_i);
      end
    end

    // R1: asynchronous reset in the middle of an R-type
    opcode_i = 6'b000000; zero_i = 1'b0; ovf_i = 1'b0;
    #2 chk_phase(P_F, "R1");
    @(negedge clk_i);
    #2 chk_phase(P_D, "R2");
    @(negedge clk_i);
    #2 chk_phase(P_RX, "R6");
    rst_ni = 1'b0;
    #2 chk_phase(P_F, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #2 chk_phase(P_F, "R1");
    @(negedge clk_i);
    #2 chk_phase(P_D, "R2");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule